// File: doc/BRIEF.md
# Supply-Fail Write Guard

This block supervises a battery-backed static memory. It watches two comparator flags, one raised when the supply drops below the deselect level and one raised when it drops below the battery switchover level. From these flags it decides when the memory must stop accepting host strobes and when the backup cell must carry the array.

When the supply sags, the guard does not cut off an access that is already under way. It opens a grace window of bounded length. Protection starts when the access ends or when the window expires, whichever comes first. Once protected, the host's select, write and read strobes are masked before they reach the memory. A deeper sag hands the array to the backup cell. That hand-over is allowed only after the supply has been good at least once since reset, so the cell stays isolated until first power-up.

When the supply returns, the guard holds protection through a long recovery interval. Any new sag during that interval starts the interval again. Both flags are resynchronised and must hold a new value for a set number of ticks before the guard reacts. All times are parameters in clock ticks.

Top module: `supply_fail_guard`

## Requirements
- R1: After reset, `guardState` is 2 (protected), `protect` is 1 and `battSel` is 0. State codes are 0 normal, 1 grace, 2 protected, 3 battery and 4 recovery.
- R2: A raw flag is acted on only after its synchronised value has differed from the filtered value for STABLE_TICKS consecutive ticks. A pulse shorter than that has no effect on `guardState`. A flag change appears on `guardState` STABLE_TICKS+3 clock edges after the first edge that samples it.
- R3: In normal state, a deselect flag with `accessBusy` low moves the guard straight to protected.
- R4: In normal state, a deselect flag with `accessBusy` high moves the guard to grace, where `protect` stays 0. The guard enters protected on the first edge that sees `accessBusy` low.
- R5: If the access is still running, grace lasts exactly WP_TICKS cycles, and the guard is then protected.
- R6: `memSel` = `hostSel` & !`protect`. `memWr` = `hostSel` & `hostWr` & !`protect`. `memRd` = `hostSel` & `hostRd` & !`hostWr` & !`protect`. In states 2, 3 and 4 all three outputs are 0 whatever the host drives.
- R7: Once powered, a filtered switchover flag moves a protected or recovering guard to battery, where `battSel` is 1. When the flag clears, the guard returns to protected and `battSel` is 0.
- R8: Before the guard has first entered recovery since reset, `battSel` stays 0 even with the switchover flag set.
- R9: Recovery is entered when the deselect flag clears in protected state. It lasts ER_TICKS cycles with the flag clear and then gives normal state. Normal is reached only from recovery.
- R10: A deselect flag seen during recovery holds the recovery timer at zero. Counting restarts from zero once the flag clears.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Free-running clock |
| rstN | input | 1 | Asynchronous active-low reset |
| rawBelowDesel | input | 1 | Comparator flag, supply below deselect level (asynchronous) |
| rawBelowSwitch | input | 1 | Comparator flag, supply below switchover level (asynchronous) |
| hostSel | input | 1 | Host chip select, active high |
| hostWr | input | 1 | Host write strobe, active high |
| hostRd | input | 1 | Host output enable, active high |
| accessBusy | input | 1 | Host access in progress |
| memSel | output | 1 | Gated select to the memory |
| memWr | output | 1 | Gated write strobe to the memory |
| memRd | output | 1 | Gated output enable; 0 means the data bus floats |
| protect | output | 1 | Memory forced deselected |
| battSel | output | 1 | Array powered from the backup cell |
| guardState | output | 3 | State code (see R1) |

## Verification
The bench builds the guard with STABLE_TICKS=3, WP_TICKS=20 and ER_TICKS=200. With these values the grace timeout and the full recovery interval finish in a few hundred cycles, so both can be checked to the exact edge. A filter length of three also lets a two-tick glitch and a longer dip be told apart. A dip during recovery is placed halfway through the interval, so a missed restart shows up as an early return to normal.

// File: rtl/sfg_pkg.sv
package sfg_pkg;
  typedef enum logic [2:0] {
    ST_NORMAL = 3'd0,
    ST_GRACE  = 3'd1,
    ST_PROT   = 3'd2,
    ST_BATT   = 3'd3,
    ST_RECOV  = 3'd4
  } guardState_e;

  typedef struct packed {
    logic timerClr;
    logic timerRun;
  } guardStrobe_t;
endpackage

// File: rtl/sfg_datapath.sv
module sfg_datapath
  import sfg_pkg::*;
#(
  parameter int STABLE_TICKS = 4,
  parameter int WP_TICKS     = 100,
  parameter int ER_TICKS     = 80000
) (
  input  logic         clk,
  input  logic         rstN,
  input  logic         rawBelowDesel,
  input  logic         rawBelowSwitch,
  input  guardStrobe_t strobe,
  output logic         lowDesel,
  output logic         lowSwitch,
  output logic         wpDone,
  output logic         erDone
);
  localparam int FW    = $clog2(STABLE_TICKS + 1);
  localparam int TMAX  = (WP_TICKS > ER_TICKS) ? WP_TICKS : ER_TICKS;
  localparam int TW    = $clog2(TMAX + 1);
  localparam int NFLAG = 2;

  logic [NFLAG-1:0] rawVec;
  logic [NFLAG-1:0] filtVec;
  assign rawVec = {rawBelowSwitch, rawBelowDesel};

  // Each flag: two-flop resync, then a persistence filter.
  for (genvar g = 0; g < NFLAG; g++) begin : gFlag
    logic syncA, syncB, filt;
    logic [FW-1:0] runCnt;
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        syncA  <= 1'b1;
        syncB  <= 1'b1;
        filt   <= 1'b1;
        runCnt <= '0;
      end else begin
        syncA <= rawVec[g];
        syncB <= syncA;
        if (syncB == filt) begin
          runCnt <= '0;
        end else if (runCnt == FW'(STABLE_TICKS - 1)) begin
          filt   <= syncB;
          runCnt <= '0;
        end else begin
          runCnt <= runCnt + 1'b1;
        end
      end
    end
    assign filtVec[g] = filt;
  end

  assign lowDesel  = filtVec[0];
  assign lowSwitch = filtVec[1];

  // One shared interval timer serves both grace and recovery.
  logic [TW-1:0] tmr;
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)               tmr <= '0;
    else if (strobe.timerClr) tmr <= '0;
    else if (strobe.timerRun) tmr <= tmr + 1'b1;
  end

  assign wpDone = (tmr == TW'(WP_TICKS - 1));
  assign erDone = (tmr == TW'(ER_TICKS - 1));
endmodule

// File: rtl/sfg_ctrl.sv
module sfg_ctrl
  import sfg_pkg::*;
(
  input  logic         clk,
  input  logic         rstN,
  input  logic         lowDesel,
  input  logic         lowSwitch,
  input  logic         wpDone,
  input  logic         erDone,
  input  logic         accessBusy,
  output guardStrobe_t strobe,
  output guardState_e  state
);
  guardState_e nextState;
  logic everPowered;

  always_comb begin
    nextState       = state;
    strobe.timerClr = 1'b0;
    strobe.timerRun = 1'b0;
    unique case (state)
      ST_NORMAL: begin
        if (lowDesel) begin
          if (accessBusy) begin
            nextState       = ST_GRACE;
            strobe.timerClr = 1'b1;
          end else begin
            nextState = ST_PROT;
          end
        end
      end
      ST_GRACE: begin
        strobe.timerRun = 1'b1;
        if (!accessBusy || wpDone) nextState = ST_PROT;
      end
      ST_PROT: begin
        if (lowSwitch && everPowered) begin
          nextState = ST_BATT;
        end else if (!lowDesel) begin
          nextState       = ST_RECOV;
          strobe.timerClr = 1'b1;
        end
      end
      ST_BATT: begin
        if (!lowSwitch) nextState = ST_PROT;
      end
      ST_RECOV: begin
        if (lowSwitch && everPowered) begin
          nextState = ST_BATT;
        end else if (lowDesel) begin
          strobe.timerClr = 1'b1;
        end else if (erDone) begin
          nextState = ST_NORMAL;
        end else begin
          strobe.timerRun = 1'b1;
        end
      end
      default: nextState = ST_PROT;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state       <= ST_PROT;
      everPowered <= 1'b0;
    end else begin
      state <= nextState;
      if (nextState == ST_RECOV) everPowered <= 1'b1;
    end
  end
endmodule

// File: rtl/supply_fail_guard.sv
module supply_fail_guard
  import sfg_pkg::*;
#(
  parameter int STABLE_TICKS = 4,
  parameter int WP_TICKS     = 100,
  parameter int ER_TICKS     = 80000
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       rawBelowDesel,
  input  logic       rawBelowSwitch,
  input  logic       hostSel,
  input  logic       hostWr,
  input  logic       hostRd,
  input  logic       accessBusy,
  output logic       memSel,
  output logic       memWr,
  output logic       memRd,
  output logic       protect,
  output logic       battSel,
  output logic [2:0] guardState
);
  guardStrobe_t strobe;
  guardState_e  state;
  logic lowDesel, lowSwitch, wpDone, erDone;

  sfg_datapath #(
    .STABLE_TICKS(STABLE_TICKS),
    .WP_TICKS(WP_TICKS),
    .ER_TICKS(ER_TICKS)
  ) uDp (
    .clk(clk), .rstN(rstN),
    .rawBelowDesel(rawBelowDesel), .rawBelowSwitch(rawBelowSwitch),
    .strobe(strobe),
    .lowDesel(lowDesel), .lowSwitch(lowSwitch),
    .wpDone(wpDone), .erDone(erDone)
  );

  sfg_ctrl uCtrl (
    .clk(clk), .rstN(rstN),
    .lowDesel(lowDesel), .lowSwitch(lowSwitch),
    .wpDone(wpDone), .erDone(erDone),
    .accessBusy(accessBusy),
    .strobe(strobe), .state(state)
  );

  assign protect    = (state != ST_NORMAL) && (state != ST_GRACE);
  assign battSel    = (state == ST_BATT);
  assign guardState = state;
  assign memSel     = hostSel & ~protect;
  assign memWr      = hostSel & hostWr & ~protect;
  assign memRd      = hostSel & hostRd & ~hostWr & ~protect;
endmodule

// File: rtl/sfg_checker.sv
module sfg_checker #(
  parameter int WP_TICKS = 100
) (
  input logic       clk,
  input logic       rstN,
  input logic [2:0] guardState,
  input logic       protect,
  input logic       battSel,
  input logic       memSel,
  input logic       memWr,
  input logic       memRd
);
  localparam int CW = $clog2(WP_TICKS + 2);
  logic [CW-1:0] graceCnt;
  logic seenRecov;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      graceCnt  <= '0;
      seenRecov <= 1'b0;
    end else begin
      graceCnt <= (guardState == 3'd1) ? graceCnt + 1'b1 : '0;
      if (guardState == 3'd4) seenRecov <= 1'b1;
    end
  end

  a_r6_masked: assert property (@(posedge clk) disable iff (!rstN)
    (guardState >= 3'd2) |-> (!memSel && !memWr && !memRd));

  a_r8_isolated: assert property (@(posedge clk) disable iff (!rstN)
    !seenRecov |-> !battSel);

  a_r5_grace_bound: assert property (@(posedge clk) disable iff (!rstN)
    (guardState == 3'd1) |-> (graceCnt < CW'(WP_TICKS)));

  a_r4_grace_entry: assert property (@(posedge clk) disable iff (!rstN)
    (guardState == 3'd1 && $past(guardState) != 3'd1) |-> $past(guardState) == 3'd0);

  a_r9_normal_entry: assert property (@(posedge clk) disable iff (!rstN)
    (guardState == 3'd0 && $past(guardState) != 3'd0) |-> $past(guardState) == 3'd4);

  a_r7_batt_entry: assert property (@(posedge clk) disable iff (!rstN)
    $rose(battSel) |-> ($past(guardState) == 3'd2 || $past(guardState) == 3'd4));
endmodule

bind supply_fail_guard sfg_checker #(.WP_TICKS(WP_TICKS)) uChk (
  .clk(clk), .rstN(rstN), .guardState(guardState), .protect(protect),
  .battSel(battSel), .memSel(memSel), .memWr(memWr), .memRd(memRd)
);

// File: tb/sim_supply_fail_guard.sv
module sim_supply_fail_guard;
  localparam int CLK_PERIOD = 10;
  localparam int ST  = 3;
  localparam int WP  = 20;
  localparam int ER  = 200;
  localparam int LAT = ST + 3;

  logic clk = 1'b0, rstN = 1'b0;
  logic rawBelowDesel = 1'b1, rawBelowSwitch = 1'b1;
  logic hostSel = 1'b0, hostWr = 1'b0, hostRd = 1'b0, accessBusy = 1'b0;
  logic memSel, memWr, memRd, protect, battSel;
  logic [2:0] guardState;
  int checks = 0, errors = 0;
  bit finished = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  supply_fail_guard #(.STABLE_TICKS(ST), .WP_TICKS(WP), .ER_TICKS(ER)) u0 (
    .clk(clk), .rstN(rstN), .rawBelowDesel(rawBelowDesel), .rawBelowSwitch(rawBelowSwitch),
    .hostSel(hostSel), .hostWr(hostWr), .hostRd(hostRd), .accessBusy(accessBusy),
    .memSel(memSel), .memWr(memWr), .memRd(memRd), .protect(protect),
    .battSel(battSel), .guardState(guardState));

  function automatic logic [2:0] expMem(logic s, logic w, logic r, logic p);
    return {s & ~p, s & w & ~p, s & r & ~w & ~p};
  endfunction

  task automatic step(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic randomStrobes(string req, int n, logic prot);
    for (int i = 0; i < n; i++) begin
      hostSel = 1'($urandom); hostWr = 1'($urandom); hostRd = 1'($urandom);
      #1;
      chk(req, {memSel, memWr, memRd}, expMem(hostSel, hostWr, hostRd, prot));
      step(1);
    end
    hostSel = 0; hostWr = 0; hostRd = 0;
  endtask

  task automatic restore(string tag);
    rawBelowDesel = 0;
    step(LAT);
    chk({tag, " R9 enter recovery"}, guardState, 4);
    step(ER - 1);
    chk({tag, " R9 still recovering"}, guardState, 4);
    step(1);
    chk({tag, " R9 normal after interval"}, guardState, 0);
  endtask

  initial begin
    void'($urandom(32'd7));
    step(3);
    chk("R1 reset state", guardState, 2);
    chk("R1 reset protect", protect, 1);
    chk("R1 reset battSel", battSel, 0);
    randomStrobes("R6 masked at reset", 6, 1);
    rstN = 1;
    step(30);
    chk("R8 battery isolated before power-up", battSel, 0);
    chk("R8 state held protected", guardState, 2);

    // Power-up: latency of filter and sync
    rawBelowDesel = 0; rawBelowSwitch = 0;
    step(LAT - 1);
    chk("R2 no reaction before filter length", guardState, 2);
    step(1);
    chk("R2 R9 recovery after filter", guardState, 4);
    randomStrobes("R6 masked in recovery", 5, 1);
    step(ER - 6);
    chk("R9 recovery held", guardState, 4);
    step(1);
    chk("R9 normal", guardState, 0);
    randomStrobes("R6 pass-through in normal", 40, 0);

    // Glitch one tick shorter than the filter
    rawBelowDesel = 1; step(ST - 1); rawBelowDesel = 0;
    step(12);
    chk("R2 short glitch ignored", guardState, 0);

    // Idle fall goes straight to protection
    rawBelowDesel = 1;
    step(LAT - 1);
    chk("R3 still normal", guardState, 0);
    step(1);
    chk("R3 protected without access", guardState, 2);
    chk("R3 protect high", protect, 1);

    // Battery hand-over
    rawBelowSwitch = 1;
    step(LAT);
    chk("R7 battery state", guardState, 3);
    chk("R7 battSel high", battSel, 1);
    randomStrobes("R6 masked on battery", 10, 1);
    rawBelowSwitch = 0;
    step(LAT);
    chk("R7 back to protected", guardState, 2);
    chk("R7 battSel low", battSel, 0);
    restore("after battery");

    // Grace ended by access completion
    hostSel = 1; hostWr = 1; accessBusy = 1; rawBelowDesel = 1;
    step(LAT);
    chk("R4 grace state", guardState, 1);
    chk("R4 protect low in grace", protect, 0);
    chk("R4 write passes in grace", memWr, 1);
    step(5);
    accessBusy = 0; hostSel = 0; hostWr = 0;
    step(1);
    chk("R4 protected after access ends", guardState, 2);
    restore("after grace");

    // Grace ended by timeout
    accessBusy = 1; rawBelowDesel = 1;
    step(LAT);
    chk("R5 grace entered", guardState, 1);
    step(WP - 1);
    chk("R5 grace last cycle", guardState, 1);
    step(1);
    chk("R5 forced protection", guardState, 2);
    accessBusy = 0;

    // Recovery with a dip halfway
    rawBelowDesel = 0;
    step(LAT);
    chk("R10 recovery entered", guardState, 4);
    step(ER / 2);
    rawBelowDesel = 1; step(ST + 2); rawBelowDesel = 0;
    step(ER);
    chk("R10 timer restarted", guardState, 4);
    step(ST + 1);
    chk("R10 recovery last cycle", guardState, 4);
    step(1);
    chk("R10 normal after restarted interval", guardState, 0);

    finished = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 20000);
    if (!finished) begin
      checks++; errors++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule